// File: doc/BRIEF.md
# Receive Frame Status Classifier

This block sits beside a 128-bit receive packet stream that carries Ethernet frames which are already decoded. It only watches the stream and never drives or changes it. Each accepted beat carries sixteen bytes, and the earliest byte of a beat sits in the top byte lane. The stream has valid, start-of-packet, end-of-packet and a 4-bit count of unused bytes on the last beat. Valid may drop at any point inside a frame, and the block keeps its parse state across those idle cycles.

For every frame the block emits a packed 40-bit status word together with a one-cycle strobe. The word sorts the destination address into broadcast, multicast or unicast. It flags VLAN and stacked-VLAN tagging. It marks MAC control frames, and among those it marks pause and priority-flow-control opcodes. It also carries the total frame length, counted through the FCS, and the payload length. The header fields the block needs can span the boundary between the first and second beat. A static input tells the block whether the FCS bytes are present on the stream or have already been stripped.

Top module: `rx_frame_status`

## Requirements
- R1: While and right after reset, stat_valid is 0 and stat_word is all zeros.
- R2: stat_valid pulses high for exactly one cycle, in the cycle after a beat with rx_valid=1 and rx_eop=1 is accepted, and at no other time. stat_word holds its value between strobes.
- R3: The destination address is bytes 0..5, where byte 0 is the first byte of the frame and is carried on rx_data[127:120] of the start beat. The address class sets exactly one of three bits. Bit 36 is set when the address is all ones. Bit 37 is set when bit 0 of byte 0 is 1 and the address is not all ones. Otherwise bit 38 is set.
- R4: Bit 33 is set when bytes 12..13 hold 0x8100. Bit 32 is set when bytes 12..13 hold 0x88A8 or 0x8100 and bytes 16..17 hold 0x8100. The tag count is 2 if bit 32 is set, else 1 if bit 33 is set, else 0.
- R5: The type field sits at byte offset 12 + 4 × tag count. If it is 0x8808, bit 34 is set. In that case the two bytes that follow are the opcode: 0x0001 sets bit 35 and 0x0101 sets bit 39. For any other type, bits 34, 35 and 39 are clear.
- R6: Bits [31:16] hold the frame length. This is 16 bytes for each accepted beat, minus rx_empty on the end beat, plus 4 when fcs_passthru is 0. The rx_empty unused bytes are the low-order byte lanes.
- R7: Bits [15:0] hold the payload length. This is the frame length minus 18 minus 4 × tag count, or 0 if that result would be negative.
- R8: Cycles with rx_valid=0 are ignored, whatever the other inputs carry. A frame delivered with idle gaps gives the same status word as the same frame delivered without gaps.
- R9: Header bytes that lie past the last byte of the frame, including unused lanes of the end beat, are read as zero when the frame is classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fcs_passthru | input | 1 | 1: FCS bytes are on the stream; 0: FCS stripped |
| rx_valid | input | 1 | Beat valid |
| rx_sop | input | 1 | First beat of a frame |
| rx_eop | input | 1 | Last beat of a frame |
| rx_empty | input | 4 | Unused low-order bytes on the end beat |
| rx_data | input | 128 | Beat data, earliest byte in [127:120] |
| stat_valid | output | 1 | One-cycle status strobe |
| stat_word | output | 40 | Per-frame status word |

## Verification
The hardest case to reach is a classification that depends on bytes which are split across beats, or missing because the frame is short. Examples are an opcode behind a stacked tag that lands in the second beat, or a type field that falls into the unused lanes of the end beat. The stimulus fills every lane past the frame end with random junk. It sweeps frame lengths from a single byte up through several beats, across every tag arrangement. Idle cycles with random sop, eop and data values are inserted inside frames, so any state lost or corrupted during a gap shows up in the status word.

// File: rtl/rxfs_pkg.sv
package rxfs_pkg;

    localparam int BUS_BYTES  = 16;
    localparam int BUS_W      = BUS_BYTES * 8;
    localparam int EMPTY_W    = $clog2(BUS_BYTES);
    localparam int LEN_W      = 16;
    localparam int HDR_BEATS  = 2;
    localparam int HDR_W      = BUS_W * HDR_BEATS;
    localparam int FCS_BYTES  = 4;
    localparam int BASE_HDR   = 14;
    localparam int TAG_BYTES  = 4;

    localparam logic [15:0] TPID_C   = 16'h8100;
    localparam logic [15:0] TPID_S   = 16'h88A8;
    localparam logic [15:0] TYPE_MAC = 16'h8808;
    localparam logic [15:0] OP_PAUSE = 16'h0001;
    localparam logic [15:0] OP_PFC   = 16'h0101;

    typedef struct packed {
        logic              pfc;
        logic              ucast;
        logic              mcast;
        logic              bcast;
        logic              pause;
        logic              ctrl;
        logic              vlan;
        logic              svlan;
        logic [LEN_W-1:0]  frame_len;
        logic [LEN_W-1:0]  payload_len;
    } status_t;

    typedef struct packed {
        logic       bcast;
        logic       mcast;
        logic       ucast;
        logic       ctrl;
        logic       pause;
        logic       pfc;
        logic       vlan;
        logic       svlan;
        logic [1:0] tags;
    } class_t;

    function automatic logic [15:0] hdr_half(input logic [HDR_W-1:0] h, input int idx);
        return h[HDR_W-1-8*idx -: 16];
    endfunction

    function automatic logic [BUS_W-1:0] mask_tail(input logic [BUS_W-1:0] d,
                                                   input logic [EMPTY_W-1:0] empty);
        logic [BUS_W-1:0] r;
        r = d;
        for (int i = 0; i < BUS_BYTES; i++) begin
            if (i < int'(empty)) r[8*i +: 8] = 8'h00;
        end
        return r;
    endfunction

    function automatic class_t classify(input logic [HDR_W-1:0] h);
        class_t      c;
        logic [47:0] da;
        logic [15:0] t12;
        logic [15:0] t16;
        logic [15:0] ety;
        logic [15:0] op;
        int          eo;
        c       = '0;
        da      = h[HDR_W-1 -: 48];
        c.bcast = &da;
        c.mcast = da[40] & ~c.bcast;
        c.ucast = ~da[40];
        t12     = hdr_half(h, 12);
        t16     = hdr_half(h, 16);
        c.vlan  = (t12 == TPID_C);
        c.svlan = ((t12 == TPID_S) || (t12 == TPID_C)) && (t16 == TPID_C);
        c.tags  = c.svlan ? 2'd2 : (c.vlan ? 2'd1 : 2'd0);
        eo      = 12 + TAG_BYTES * int'(c.tags);
        ety     = hdr_half(h, eo);
        op      = hdr_half(h, eo + 2);
        c.ctrl  = (ety == TYPE_MAC);
        c.pause = c.ctrl && (op == OP_PAUSE);
        c.pfc   = c.ctrl && (op == OP_PFC);
        return c;
    endfunction

endpackage

// File: rtl/rxfs_hdr_capture.sv
module rxfs_hdr_capture
    import rxfs_pkg::*;
#(
    parameter int BEATS = HDR_BEATS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fire,
    input  logic                    sop,
    input  logic                    eop,
    input  logic [EMPTY_W-1:0]      empty,
    input  logic [BUS_W-1:0]        data,
    output logic [BUS_W*BEATS-1:0]  hdr_view
);
    localparam int IDX_W = $clog2(BEATS + 1);

    logic [IDX_W-1:0] beat_idx;
    logic [IDX_W-1:0] idx_now;
    logic [BUS_W-1:0] cur;
    logic [BUS_W-1:0] slot_q    [BEATS];
    logic [BUS_W-1:0] slot_view [BEATS];

    assign idx_now = sop ? '0 : beat_idx;
    assign cur     = eop ? mask_tail(data, empty) : data;

    for (genvar b = 0; b < BEATS; b++) begin : g_slot
        always_comb begin
            if (fire && (idx_now == IDX_W'(b)))
                slot_view[b] = cur;
            else if (fire && sop)
                slot_view[b] = '0;
            else
                slot_view[b] = slot_q[b];
        end

        always_ff @(posedge clk) begin
            if (rst)
                slot_q[b] <= '0;
            else if (fire)
                slot_q[b] <= slot_view[b];
        end

        assign hdr_view[BUS_W*(BEATS-b)-1 -: BUS_W] = slot_view[b];
    end

    always_ff @(posedge clk) begin
        if (rst)
            beat_idx <= '0;
        else if (fire)
            beat_idx <= (idx_now < IDX_W'(BEATS)) ? idx_now + 1'b1 : idx_now;
    end

endmodule

// File: rtl/rxfs_len_count.sv
module rxfs_len_count
    import rxfs_pkg::*;
#(
    parameter int CW = LEN_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic               sop,
    input  logic               eop,
    input  logic [EMPTY_W-1:0] empty,
    output logic [CW-1:0]      total
);
    logic [CW-1:0] acc_q;
    logic [CW-1:0] base;
    logic [CW-1:0] beat_bytes;
    logic [CW:0]   sum;

    assign base       = sop ? '0 : acc_q;
    assign beat_bytes = CW'(BUS_BYTES) - (eop ? CW'(empty) : '0);
    assign sum        = {1'b0, base} + {1'b0, beat_bytes};
    assign total      = sum[CW] ? '1 : sum[CW-1:0];

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (fire)
            acc_q <= total;
    end

endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
    import rxfs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fcs_passthru,
    input  logic               rx_valid,
    input  logic               rx_sop,
    input  logic               rx_eop,
    input  logic [EMPTY_W-1:0] rx_empty,
    input  logic [BUS_W-1:0]   rx_data,
    output logic               stat_valid,
    output logic [39:0]        stat_word
);
    logic [HDR_W-1:0] hdr_view;
    logic [LEN_W-1:0] seen_bytes;
    logic [LEN_W:0]   len_sum;
    logic [LEN_W-1:0] frame_len;
    logic [LEN_W-1:0] overhead;
    logic [LEN_W-1:0] payload_len;
    class_t           cls;
    status_t          stat_d;
    status_t          stat_q;
    logic             done;

    assign done = rx_valid & rx_eop;

    rxfs_hdr_capture #(.BEATS(HDR_BEATS)) u_hdr (
        .clk      (clk),
        .rst      (rst),
        .fire     (rx_valid),
        .sop      (rx_sop),
        .eop      (rx_eop),
        .empty    (rx_empty),
        .data     (rx_data),
        .hdr_view (hdr_view)
    );

    rxfs_len_count #(.CW(LEN_W)) u_len (
        .clk   (clk),
        .rst   (rst),
        .fire  (rx_valid),
        .sop   (rx_sop),
        .eop   (rx_eop),
        .empty (rx_empty),
        .total (seen_bytes)
    );

    always_comb begin
        cls         = classify(hdr_view);
        len_sum     = {1'b0, seen_bytes} + (fcs_passthru ? '0 : (LEN_W+1)'(FCS_BYTES));
        frame_len   = len_sum[LEN_W] ? '1 : len_sum[LEN_W-1:0];
        overhead    = LEN_W'(BASE_HDR + FCS_BYTES + TAG_BYTES * int'(cls.tags));
        payload_len = (frame_len > overhead) ? frame_len - overhead : '0;

        stat_d.pfc         = cls.pfc;
        stat_d.ucast       = cls.ucast;
        stat_d.mcast       = cls.mcast;
        stat_d.bcast       = cls.bcast;
        stat_d.pause       = cls.pause;
        stat_d.ctrl        = cls.ctrl;
        stat_d.vlan        = cls.vlan;
        stat_d.svlan       = cls.svlan;
        stat_d.frame_len   = frame_len;
        stat_d.payload_len = payload_len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q     <= '0;
            stat_valid <= 1'b0;
        end else begin
            stat_valid <= done;
            if (done) stat_q <= stat_d;
        end
    end

    assign stat_word = stat_q;

endmodule

// File: rtl/rx_frame_status_chk.sv
module rx_frame_status_chk (
    input logic        clk,
    input logic        rst,
    input logic        rx_valid,
    input logic        rx_eop,
    input logic        stat_valid,
    input logic [39:0] stat_word
);
    // R2
    strobe_after_end_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_eop) |=> stat_valid);

    // R2
    no_spurious_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rx_eop) |=> !stat_valid);

    // R2
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stat_valid |-> $stable(stat_word));

    // R3
    addr_class_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> ($countones(stat_word[38:36]) == 1));

    // R5
    opcode_needs_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && (stat_word[39] || stat_word[35])) |-> stat_word[34]);

    // R5
    opcode_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> $onehot0({stat_word[39], stat_word[35]}));

    // R7
    payload_bound_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> (stat_word[15:0] <= stat_word[31:16]));

endmodule

bind rx_frame_status rx_frame_status_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_eop     (rx_eop),
    .stat_valid (stat_valid),
    .stat_word  (stat_word)
);

// File: tb/rx_frame_status_bench.sv
module rx_frame_status_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fcs_passthru = 1'b0;
    logic         rx_valid = 1'b0;
    logic         rx_sop = 1'b0;
    logic         rx_eop = 1'b0;
    logic [3:0]   rx_empty = '0;
    logic [127:0] rx_data = '0;
    logic         stat_valid;
    logic [39:0]  stat_word;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [7:0] fr [0:255];
    int         n;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_frame_status u_rx_frame_status (
        .clk          (clk),
        .rst          (rst),
        .fcs_passthru (fcs_passthru),
        .rx_valid     (rx_valid),
        .rx_sop       (rx_sop),
        .rx_eop       (rx_eop),
        .rx_empty     (rx_empty),
        .rx_data      (rx_data),
        .stat_valid   (stat_valid),
        .stat_word    (stat_word)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog expired act=%0d exp<%0d", cycles, WATCHDOG);
            summary();
        end
    end

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] g(input int i);
        return (i < n) ? fr[i] : 8'h00;
    endfunction

    function automatic logic [15:0] g16(input int i);
        return {g(i), g(i + 1)};
    endfunction

    function automatic logic [39:0] expect_word(input logic pass);
        logic        bc, mc, uc, vl, sv, ct, pa, pf;
        int          tags, eo, fl, pl;
        logic [15:0] t12, ety, op;
        bc   = (g(0) & g(1) & g(2) & g(3) & g(4) & g(5)) == 8'hFF;
        mc   = g(0)[0] && !bc;
        uc   = !g(0)[0];
        t12  = g16(12);
        vl   = (t12 == 16'h8100);
        sv   = ((t12 == 16'h88A8) || (t12 == 16'h8100)) && (g16(16) == 16'h8100);
        tags = sv ? 2 : (vl ? 1 : 0);
        eo   = 12 + 4 * tags;
        ety  = g16(eo);
        op   = g16(eo + 2);
        ct   = (ety == 16'h8808);
        pa   = ct && (op == 16'h0001);
        pf   = ct && (op == 16'h0101);
        fl   = n + (pass ? 0 : 4);
        pl   = fl - 18 - 4 * tags;
        if (pl < 0) pl = 0;
        return {pf, uc, mc, bc, pa, ct, vl, sv, 16'(fl), 16'(pl)};
    endfunction

    // dak: 0 bcast, 1 mcast, 2 ucast; tgk: 0 none, 1 C-tag, 2 S+C, 3 C+C, 4 lone S
    // ctk: 0 plain type, 1 pause, 2 PFC, 3 other control opcode
    task automatic build(input int dak, input int tgk, input int ctk, input int len);
        int p;
        for (int i = 0; i < 256; i++) fr[i] = 8'($urandom);
        case (dak)
            0: for (int i = 0; i < 6; i++) fr[i] = 8'hFF;
            1: begin fr[0] = fr[0] | 8'h01; fr[1] = 8'h00; end
            default: fr[0] = fr[0] & 8'hFE;
        endcase
        p = 12;
        case (tgk)
            1: begin fr[12] = 8'h81; fr[13] = 8'h00; p = 16; end
            2: begin fr[12] = 8'h88; fr[13] = 8'hA8; fr[16] = 8'h81; fr[17] = 8'h00; p = 20; end
            3: begin fr[12] = 8'h81; fr[13] = 8'h00; fr[16] = 8'h81; fr[17] = 8'h00; p = 20; end
            4: begin fr[12] = 8'h88; fr[13] = 8'hA8; fr[16] = 8'h08; fr[17] = 8'h00; p = -1; end
            default: p = 12;
        endcase
        if (p >= 0) begin
            if (ctk == 0) begin
                fr[p] = 8'h08; fr[p+1] = 8'h00;
            end else begin
                fr[p] = 8'h88; fr[p+1] = 8'h08;
                case (ctk)
                    1: begin fr[p+2] = 8'h00; fr[p+3] = 8'h01; end
                    2: begin fr[p+2] = 8'h01; fr[p+3] = 8'h01; end
                    default: begin fr[p+2] = 8'h7E; fr[p+3] = 8'h33; end
                endcase
            end
        end
        n = len;
    endtask

    task automatic idle_junk();
        rx_valid = 1'b0;
        rx_sop   = 1'($urandom);
        rx_eop   = 1'($urandom);
        rx_empty = 4'($urandom);
        rx_data  = {$urandom, $urandom, $urandom, $urandom};
        @(posedge clk); #1;
    endtask

    // sends frame in fr[0..n-1]; checks strobe and fields
    task automatic send(input logic pass, input bit gaps, input string tag);
        int          nb;
        logic [39:0] exp;
        logic [39:0] held;
        fcs_passthru = pass;
        nb  = (n + 15) / 16;
        exp = expect_word(pass);
        for (int b = 0; b < nb; b++) begin
            if (gaps && b > 0) begin
                for (int k = 0; k < int'($urandom % 3); k++) idle_junk();
            end
            rx_valid = 1'b1;
            rx_sop   = (b == 0);
            rx_eop   = (b == nb - 1);
            rx_empty = (b == nb - 1) ? 4'(16 * nb - n) : 4'($urandom);
            for (int j = 0; j < 16; j++) rx_data[127 - 8*j -: 8] = fr[16*b + j];
            @(posedge clk); #1;
        end
        rx_valid = 1'b0;
        rx_sop   = 1'b0;
        rx_eop   = 1'b0;
        chk({tag, " R2 strobe"}, {39'd0, stat_valid}, 40'd1);
        chk({tag, " R3 class"}, {37'd0, stat_word[38:36]}, {37'd0, exp[38:36]});
        chk({tag, " R4 vlan"}, {38'd0, stat_word[33:32]}, {38'd0, exp[33:32]});
        chk({tag, " R5 ctrl"}, {37'd0, stat_word[39], stat_word[35:34]},
            {37'd0, exp[39], exp[35:34]});
        chk({tag, " R6 frame_len"}, {24'd0, stat_word[31:16]}, {24'd0, exp[31:16]});
        chk({tag, " R7 payload"}, {24'd0, stat_word[15:0]}, {24'd0, exp[15:0]});
        held = stat_word;
        idle_junk();
        chk({tag, " R2 one-cycle"}, {39'd0, stat_valid}, 40'd0);
        idle_junk();
        chk({tag, " R8 idle ignored"}, stat_word, held);
    endtask

    initial begin
        void'($urandom(32'h5A17C0DE));
        repeat (4) @(posedge clk);
        #1;
        chk("R1 valid in reset", {39'd0, stat_valid}, 40'd0);
        chk("R1 word in reset", stat_word, 40'd0);
        rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 valid after reset", {39'd0, stat_valid}, 40'd0);
        chk("R1 word after reset", stat_word, 40'd0);

        // directed corners
        build(0, 0, 1, 64);  send(1'b0, 1'b0, "pause bcast R5");
        build(1, 3, 2, 80);  send(1'b1, 1'b0, "pfc stacked straddle R5");
        build(2, 2, 1, 24);  send(1'b0, 1'b0, "opcode ends at byte 24 R4");
        build(2, 2, 1, 22);  send(1'b0, 1'b0, "opcode cut short R9");
        build(0, 0, 0, 1);   send(1'b0, 1'b0, "one byte R9");
        build(2, 1, 0, 16);  send(1'b1, 1'b0, "exact beat R6");
        build(2, 1, 0, 17);  send(1'b1, 1'b0, "one into beat R6");
        build(1, 4, 1, 60);  send(1'b0, 1'b0, "lone S-tag R4");
        build(2, 1, 2, 100); send(1'b0, 1'b1, "gapped pfc R8");
        build(1, 0, 0, 10);  send(1'b1, 1'b0, "payload floor R7");

        for (int t = 0; t < 400; t++) begin
            build(int'($urandom % 3), int'($urandom % 5), int'($urandom % 4),
                  1 + int'($urandom % 200));
            send(1'($urandom), 1'($urandom), "random R8");
        end
        summary();
    end

endmodule